// File: doc/BRIEF.md
# Dual-Port Memory With Mailbox Interrupts

This block is a shared dual-port RAM with two fully independent ports, left and right. Each port has an enable, an output enable, a write select, a word address, write data and a registered read-data path. Both ports are synchronous to one clock. Any location can be read or written from either side in the same cycle.

The two highest addresses also serve as doorbells between the two sides. A left-side write to the top address raises an interrupt towards the right side, and the right side clears it by reading that address. A right-side write to the address just below the top raises an interrupt towards the left side, and the left side clears it by reading that address. The data written to these two words is kept as ordinary memory contents, so the pair also works as a small message box.

The address width is a parameter. The full configuration uses 14 address bits (16384 words) and 9-bit data. The default build uses 11 address bits so that the array stays small during elaboration. The doorbell addresses always follow the top of whatever address space is configured.

Top module: `dual_port_doorbell_ram`

## Requirements
- R1: After reset both interrupt outputs (lIntN, rIntN) are high, and both read-drive flags (lDrive, rDrive) are low with read data 0.
- R2: A read happens on a port when en=1, outEn=1 and write=0. The word at that address appears on the port's read data, with its drive flag high, after the next rising clock edge.
- R3: A port with en=0, or with outEn=0 and write=0, drives no data: after the edge its drive flag is 0 and its read data is 0. A port with en=0 and write=1 does not change memory.
- R4: When one port writes an address and the other port reads the same address in the same cycle, the read returns the old word. A read of that address in the following cycle returns the new word.
- R5: A left write (en=1, write=1) to the top address (all address bits 1) drives rIntN low after that clock edge.
- R6: A right read of the top address drives rIntN high after that edge. A left read of the top address leaves rIntN unchanged.
- R7: A right write to the top address minus one drives lIntN low after that edge. A left read of that address drives it high again. A right read of that address leaves lIntN unchanged.
- R8: The words written to the two doorbell addresses are stored and read back like any other location.
- R9: If a doorbell flag is set and cleared in the same cycle, setting wins and the interrupt stays asserted (low).
- R10: If both ports write the same address in the same cycle, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Active-low asynchronous reset of flags and read drive |
| lEn | input | 1 | Left port enable |
| lOutEn | input | 1 | Left port output enable |
| lWrite | input | 1 | Left port write select (1 = write) |
| lAddr | input | AddrW | Left port word address |
| lWData | input | DataW | Left port write data |
| lRData | output | DataW | Left port read data, 0 when not driven |
| lDrive | output | 1 | Left read data is valid and driven |
| lIntN | output | 1 | Active-low interrupt to the left side |
| rEn | input | 1 | Right port enable |
| rOutEn | input | 1 | Right port output enable |
| rWrite | input | 1 | Right port write select (1 = write) |
| rAddr | input | AddrW | Right port word address |
| rWData | input | DataW | Right port write data |
| rRData | output | DataW | Right port read data, 0 when not driven |
| rDrive | output | 1 | Right read data is valid and driven |
| rIntN | output | 1 | Active-low interrupt to the right side |

## Verification
Several pairs of functions can fall in the same cycle. A doorbell can be set by one side while the other side clears it by reading. A write from one side can meet a read of the same word from the other side. The bench provokes these by weighting random addresses heavily towards the two doorbell words and a handful of low addresses, and it adds directed cycles that force each pair exactly. Every cycle is judged against a bench model in which reads see the memory before that cycle's writes, setting a flag beats clearing it, and the left write beats the right write.

// File: rtl/dpdb_pkg.sv
package dpdb_pkg;
  // Qualified per-cycle memory strobes from control to datapath.
  typedef struct packed {
    logic lWr;
    logic rWr;
    logic lRd;
    logic rRd;
  } memStrobes_t;
endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import dpdb_pkg::*;
#(
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lEn,
  input  logic             lOutEn,
  input  logic             lWrite,
  input  logic [AddrW-1:0] lAddr,
  input  logic             rEn,
  input  logic             rOutEn,
  input  logic             rWrite,
  input  logic [AddrW-1:0] rAddr,
  output memStrobes_t      strobes,
  output logic             lIntN,
  output logic             rIntN
);
  localparam logic [AddrW-1:0] ToRightAddr = {AddrW{1'b1}};
  localparam logic [AddrW-1:0] ToLeftAddr  = ToRightAddr - 1'b1;

  logic rightFlag, leftFlag;
  logic setRight, clrRight, setLeft, clrLeft;

  always_comb begin
    strobes.lWr = lEn & lWrite;
    strobes.rWr = rEn & rWrite;
    strobes.lRd = lEn & lOutEn & ~lWrite;
    strobes.rRd = rEn & rOutEn & ~rWrite;
  end

  assign setRight = strobes.lWr & (lAddr == ToRightAddr);
  assign clrRight = strobes.rRd & (rAddr == ToRightAddr);
  assign setLeft  = strobes.rWr & (rAddr == ToLeftAddr);
  assign clrLeft  = strobes.lRd & (lAddr == ToLeftAddr);

  // Setting has priority over clearing so that a new message is never lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightFlag <= 1'b0;
      leftFlag  <= 1'b0;
    end else begin
      if (setRight)      rightFlag <= 1'b1;
      else if (clrRight) rightFlag <= 1'b0;
      if (setLeft)       leftFlag  <= 1'b1;
      else if (clrLeft)  leftFlag  <= 1'b0;
    end
  end

  assign lIntN = ~leftFlag;
  assign rIntN = ~rightFlag;
endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath
  import dpdb_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int DataW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  memStrobes_t      strobes,
  input  logic [AddrW-1:0] lAddr,
  input  logic [DataW-1:0] lWData,
  input  logic [AddrW-1:0] rAddr,
  input  logic [DataW-1:0] rWData,
  output logic [DataW-1:0] lRData,
  output logic             lDrive,
  output logic [DataW-1:0] rRData,
  output logic             rDrive
);
  localparam int Depth = 1 << AddrW;
  localparam int NumPorts = 2;

  logic [DataW-1:0] mem [Depth];

  // Right is written first so a same-address left write lands last.
  always_ff @(posedge clk) begin
    if (strobes.rWr) mem[rAddr] <= rWData;
    if (strobes.lWr) mem[lAddr] <= lWData;
  end

  logic [AddrW-1:0] portAddr [NumPorts];
  logic             portRd   [NumPorts];
  logic [DataW-1:0] portData [NumPorts];
  logic             portDrv  [NumPorts];

  assign portAddr[0] = lAddr;
  assign portAddr[1] = rAddr;
  assign portRd[0]   = strobes.lRd;
  assign portRd[1]   = strobes.rRd;

  for (genvar p = 0; p < NumPorts; p++) begin : g_readPort
    logic [DataW-1:0] dataQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ      <= '0;
        portDrv[p] <= 1'b0;
      end else begin
        portDrv[p] <= portRd[p];
        if (portRd[p]) dataQ <= mem[portAddr[p]];
      end
    end
    assign portData[p] = portDrv[p] ? dataQ : '0;
  end

  assign lRData = portData[0];
  assign lDrive = portDrv[0];
  assign rRData = portData[1];
  assign rDrive = portDrv[1];
endmodule

// File: rtl/dual_port_doorbell_ram.sv
module dual_port_doorbell_ram
  import dpdb_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int DataW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lEn,
  input  logic             lOutEn,
  input  logic             lWrite,
  input  logic [AddrW-1:0] lAddr,
  input  logic [DataW-1:0] lWData,
  output logic [DataW-1:0] lRData,
  output logic             lDrive,
  output logic             lIntN,
  input  logic             rEn,
  input  logic             rOutEn,
  input  logic             rWrite,
  input  logic [AddrW-1:0] rAddr,
  input  logic [DataW-1:0] rWData,
  output logic [DataW-1:0] rRData,
  output logic             rDrive,
  output logic             rIntN
);
  memStrobes_t strobes;

  doorbell_ctrl #(.AddrW(AddrW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lOutEn(lOutEn), .lWrite(lWrite), .lAddr(lAddr),
    .rEn(rEn), .rOutEn(rOutEn), .rWrite(rWrite), .rAddr(rAddr),
    .strobes(strobes), .lIntN(lIntN), .rIntN(rIntN)
  );

  dpram_datapath #(.AddrW(AddrW), .DataW(DataW)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lAddr(lAddr), .lWData(lWData), .rAddr(rAddr), .rWData(rWData),
    .lRData(lRData), .lDrive(lDrive), .rRData(rRData), .rDrive(rDrive)
  );
endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk #(
  parameter int AddrW = 11,
  parameter int DataW = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             lEn,
  input logic             lOutEn,
  input logic             lWrite,
  input logic [AddrW-1:0] lAddr,
  input logic [DataW-1:0] lRData,
  input logic             lDrive,
  input logic             lIntN,
  input logic             rEn,
  input logic             rOutEn,
  input logic             rWrite,
  input logic [AddrW-1:0] rAddr,
  input logic [DataW-1:0] rRData,
  input logic             rDrive,
  input logic             rIntN
);
  localparam logic [AddrW-1:0] TopA  = {AddrW{1'b1}};
  localparam logic [AddrW-1:0] NextA = TopA - 1'b1;

  // R3
  left_idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lEn |=> (!lDrive && lRData == '0));

  // R3
  right_idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rEn |=> (!rDrive && rRData == '0));

  // R5
  right_bell_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lEn && lWrite && lAddr == TopA) |=> !rIntN);

  // R6
  right_bell_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rEn && rOutEn && !rWrite && rAddr == TopA && !(lEn && lWrite && lAddr == TopA))
      |=> rIntN);

  // R7
  left_bell_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rEn && rWrite && rAddr == NextA) |=> !lIntN);

  // R7
  left_bell_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lEn && lOutEn && !lWrite && lAddr == NextA && !(rEn && rWrite && rAddr == NextA))
      |=> lIntN);

  // R6
  right_bell_own_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rIntN && !(rEn && rOutEn && !rWrite && rAddr == TopA)) |=> !rIntN);
endmodule

bind dual_port_doorbell_ram doorbell_chk #(.AddrW(AddrW), .DataW(DataW)) u_chk (.*);

// File: tb/test_dual_port_doorbell_ram.sv
module test_dual_port_doorbell_ram;
  localparam int AW = 11;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int TOP = DEPTH - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lEn = 0, lOutEn = 0, lWrite = 0, rEn = 0, rOutEn = 0, rWrite = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWData = '0, rWData = '0;
  logic [DW-1:0] lRData, rRData;
  logic lDrive, rDrive, lIntN, rIntN;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] model [DEPTH];
  bit mLeftFlag = 0, mRightFlag = 0;

  always #4 clk = ~clk;

  dual_port_doorbell_ram #(.AddrW(AW), .DataW(DW)) i_dual_port_doorbell_ram (.*);

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: predict from the requirements, clock it, compare after the edge.
  task automatic step(string tag);
    bit lRd, rRd, lWr, rWr;
    logic [DW-1:0] expL, expR;
    lRd = lEn && lOutEn && !lWrite;
    rRd = rEn && rOutEn && !rWrite;
    lWr = lEn && lWrite;
    rWr = rEn && rWrite;
    expL = lRd ? model[lAddr] : '0;
    expR = rRd ? model[rAddr] : '0;
    if (rWr) model[rAddr] = rWData;
    if (lWr) model[lAddr] = lWData;
    if (lWr && lAddr == TOP) mRightFlag = 1;
    else if (rRd && rAddr == TOP) mRightFlag = 0;
    if (rWr && rAddr == TOP - 1) mLeftFlag = 1;
    else if (lRd && lAddr == TOP - 1) mLeftFlag = 0;
    @(negedge clk);
    check(tag, "lDrive", lDrive, lRd);
    check(tag, "rDrive", rDrive, rRd);
    check(tag, "lRData", lRData, expL);
    check(tag, "rRData", rRData, expR);
    check(tag, "lIntN", lIntN, !mLeftFlag);
    check(tag, "rIntN", rIntN, !mRightFlag);
  endtask

  task automatic idle();
    lEn = 0; lOutEn = 0; lWrite = 0; rEn = 0; rOutEn = 0; rWrite = 0;
  endtask
  task automatic lOp(bit wr, int a, int d);
    lEn = 1; lOutEn = !wr; lWrite = wr; lAddr = AW'(a); lWData = DW'(d);
  endtask
  task automatic rOp(bit wr, int a, int d);
    rEn = 1; rOutEn = !wr; rWrite = wr; rAddr = AW'(a); rWData = DW'(d);
  endtask

  function automatic int pickAddr(int sel);
    case (sel % 4)
      0: return TOP;
      1: return TOP - 1;
      2: return int'($urandom % 8);
      default: return int'($urandom % DEPTH);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "lIntN", lIntN, 1);
    check("R1", "rIntN", rIntN, 1);
    check("R1", "lDrive", lDrive, 0);
    check("R1", "rData", rRData, 0);
    rstN = 1;
    @(negedge clk);

    // Fill memory so every word has a known value (R8 covers doorbell words).
    for (int a = 0; a < DEPTH; a++) begin
      idle(); lOp(1, a, (a * 7 + 3) & 9'h1FF);
      step("R8");
    end
    check("R5", "rIntN after top write", rIntN, 0);
    // R6: left reading its own outgoing top address does not clear
    idle(); lOp(0, TOP, 0); step("R6");
    check("R6", "rIntN after left read", rIntN, 0);
    // R6: right read clears, R8: data kept
    idle(); rOp(0, TOP, 0); step("R6");
    check("R8", "top word", rRData, (TOP * 7 + 3) & 9'h1FF);

    // R2: write then read on same port
    idle(); lOp(1, 5, 9'h15A); step("R2");
    idle(); lOp(0, 5, 0); step("R2");
    check("R2", "readback", lRData, 9'h15A);

    // R3: outEn low and en low
    idle(); lEn = 1; lOutEn = 0; lAddr = 5; step("R3");
    idle(); lEn = 0; lWrite = 1; lAddr = 5; lWData = 9'h0AA; step("R3");
    idle(); rOp(0, 5, 0); step("R3");
    check("R3", "no write when disabled", rRData, 9'h15A);

    // R4: collision, old then new
    idle(); lOp(1, 9, 9'h1C3); rOp(0, 9, 0); step("R4");
    check("R4", "old data", rRData, (9 * 7 + 3) & 9'h1FF);
    idle(); rOp(0, 9, 0); step("R4");
    check("R4", "new data", rRData, 9'h1C3);

    // R7: left doorbell set, right reading it leaves it, left read clears
    idle(); rOp(1, TOP - 1, 9'h033); step("R7");
    idle(); rOp(0, TOP - 1, 0); step("R7");
    check("R7", "lIntN held", lIntN, 0);
    idle(); lOp(0, TOP - 1, 0); step("R7");
    check("R7", "lIntN cleared", lIntN, 1);

    // R9: set and clear in the same cycle
    idle(); lOp(1, TOP, 9'h101); rOp(0, TOP, 0); step("R9");
    check("R9", "rIntN stays low", rIntN, 0);
    idle(); rOp(0, TOP, 0); step("R9");

    // R10: both write same address
    idle(); lOp(1, 3, 9'h111); rOp(1, 3, 9'h0EE); step("R10");
    idle(); rOp(0, 3, 0); step("R10");
    check("R10", "left wins", rRData, 9'h111);

    // Random mix, weighted towards doorbells and a few low addresses (R2/R4/R5/R6/R7/R9)
    for (int i = 0; i < 4000; i++) begin
      lEn = 1'($urandom % 4 != 0); lOutEn = 1'($urandom % 3 != 0);
      lWrite = 1'($urandom % 2); lAddr = AW'(pickAddr(int'($urandom)));
      lWData = DW'($urandom);
      rEn = 1'($urandom % 4 != 0); rOutEn = 1'($urandom % 3 != 0);
      rWrite = 1'($urandom % 2); rAddr = AW'(pickAddr(int'($urandom)));
      rWData = DW'($urandom);
      step("R4");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule